// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line in a small direct-mapped private cache that sits on a broadcast snoop bus shared with peer caches. Each line is in one of five states: Invalid, Shared, Exclusive, Owned or Modified. A line holds one data word. Processor reads and writes that hit a suitable state finish in the same cycle with no bus traffic. Any other access raises a bus request whose command is worked out from the line state: read, read-exclusive, upgrade, or writeback of a dirty victim. The line is updated in the cycle the bus arbiter grants the request.

The block also watches the transactions that other caches place on the bus. When a snooped address matches a valid local line, the block drives the shared response in the same cycle. It supplies the line's data when it holds the dirty copy, and it downgrades or invalidates the line at the next edge. Dirty data can be handed to a reader without first being written to memory: the holder moves to Owned and stays responsible for the eventual writeback.

The processor holds its request stable until `cpu_done`. The arbiter raises `bus_gnt` for one cycle, and only while `bus_req` is high. In a granted cycle it presents `bus_shared_in` and `bus_fill_data`, and it never grants in a cycle that carries a snoop.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. With no processor request `bus_req` is low, and a snoop to any address gets neither `snp_shared` nor `snp_supply`.
- R2: A processor read whose tag matches a valid line completes in that cycle with `cpu_done` high, `bus_req` low and `cpu_rdata` equal to the line's data.
- R3: A read miss drives `bus_req` with `bus_cmd` = 0 (read). On grant the line takes `bus_fill_data`, and it becomes Exclusive if `bus_shared_in` is low and Shared if it is high.
- R4: A write to a line in Exclusive or Modified completes in the same cycle without a bus request, stores `cpu_wdata`, and leaves the line Modified.
- R5: A write to a line in Shared or Owned requests `bus_cmd` = 2 (upgrade). On grant the line becomes Modified and keeps its data, and the write then completes.
- R6: A write miss requests `bus_cmd` = 1 (read-exclusive). On grant the line becomes Modified with `bus_fill_data`, and the write then completes.
- R7: A miss whose victim line is Modified or Owned first requests `bus_cmd` = 3 (writeback), with the victim's address on `bus_addr` and its data on `bus_wdata`. The victim becomes Invalid on grant. A Shared or Exclusive victim is dropped without any bus request.
- R8: A snooped read (`snp_cmd` = 0) hitting a valid line asserts `snp_shared`. From Modified or Owned it also asserts `snp_supply` with the line's data on `snp_data`, and the line ends in Owned. Exclusive becomes Shared, and Shared stays Shared.
- R9: A snooped read-exclusive (`snp_cmd` = 1) or upgrade (`snp_cmd` = 2) hitting a valid line invalidates it. Only a read-exclusive makes a Modified or Owned line supply its data.
- R10: A snoop that misses, or a snooped writeback (`snp_cmd` = 3), gets no response and leaves the line unchanged.
- R11: In a cycle with `snp_valid` high, `cpu_done` is low. A pending request's command is re-derived from the state the snoop leaves, so an upgrade whose Shared line is invalidated becomes a read-exclusive.
- R12: While a miss is pending and neither a grant nor a snoop occurs, `bus_req` stays high and `bus_cmd` and `bus_addr` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address (tag above index) |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data of the addressed line |
| bus_req | output | 1 | Bus request for the pending miss |
| bus_gnt | input | 1 | One-cycle grant; the transaction occurs in this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Writeback data |
| bus_shared_in | input | 1 | A peer holds the line (sampled on grant) |
| bus_fill_data | input | DW | Fill data for read and read-exclusive |
| snp_valid | input | 1 | Peer transaction on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | Local valid copy present |
| snp_supply | output | 1 | Local cache drives the data |
| snp_data | output | DW | Supplied data |

## Verification
The assertions check on every cycle the rules that relate handshake signals: completion and bus request never coincide, no completion happens during a snoop, and supplying data implies the shared response. They also check that a waiting request keeps its command and address, that a granted writeback is not requested again, and that a granted fill lets the held access finish next cycle. The state walk needs the bench's scenarios, which keep a reference copy of every line's state, tag and data: E to M on a silent write, M to O to O under repeated snooped reads, a victim writeback followed by a refill, and an upgrade turned into a read-exclusive by an invalidating snoop. Random traffic with conflicting tags and snoops injected between request and grant covers the remaining combinations.

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl #(
  parameter int AW   = 12,
  parameter int IDXW = 2,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_shared_in,
  input  logic [DW-1:0] bus_fill_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_supply,
  output logic [DW-1:0] snp_data
);
  localparam int NLINES = 1 << IDXW;
  localparam int TAGW   = AW - IDXW;

  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  logic [2:0]      st_q   [NLINES];
  logic [TAGW-1:0] tag_q  [NLINES];
  logic [DW-1:0]   data_q [NLINES];

  logic [IDXW-1:0] cidx, sidx;
  logic [TAGW-1:0] ctag, stag;
  logic [2:0]      cst, sst;
  logic            cmatch, smatch, hit_ok, need_wb, dirty_c, dirty_s;

  assign cidx    = cpu_addr[IDXW-1:0];
  assign ctag    = cpu_addr[AW-1:IDXW];
  assign cst     = st_q[cidx];
  assign cmatch  = (cst != ST_I) && (tag_q[cidx] == ctag);
  assign dirty_c = (cst == ST_M) || (cst == ST_O);
  assign hit_ok  = cmatch && (!cpu_we || cst == ST_M || cst == ST_E);
  assign need_wb = !cmatch && dirty_c;

  assign cpu_done  = cpu_req && hit_ok && !snp_valid;
  assign cpu_rdata = data_q[cidx];
  assign bus_req   = cpu_req && !hit_ok;
  assign bus_cmd   = need_wb ? C_WB : (!cpu_we ? C_RD : (cmatch ? C_UPG : C_RDX));
  assign bus_addr  = need_wb ? {tag_q[cidx], cidx} : cpu_addr;
  assign bus_wdata = data_q[cidx];

  assign sidx    = snp_addr[IDXW-1:0];
  assign stag    = snp_addr[AW-1:IDXW];
  assign sst     = st_q[sidx];
  assign smatch  = (sst != ST_I) && (tag_q[sidx] == stag);
  assign dirty_s = (sst == ST_M) || (sst == ST_O);

  assign snp_shared = snp_valid && smatch && (snp_cmd != C_WB);
  assign snp_supply = snp_valid && smatch && dirty_s && (snp_cmd == C_RD || snp_cmd == C_RDX);
  assign snp_data   = data_q[sidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (snp_valid) begin
      if (smatch) begin
        case (snp_cmd)
          C_RD: begin
            if (sst == ST_M) st_q[sidx] <= ST_O;
            else if (sst == ST_E) st_q[sidx] <= ST_S;
          end
          C_RDX, C_UPG: st_q[sidx] <= ST_I;
          default: ;
        endcase
      end
    end else if (bus_req && bus_gnt) begin
      case (bus_cmd)
        C_WB:  st_q[cidx] <= ST_I;
        C_UPG: st_q[cidx] <= ST_M;
        C_RD: begin
          st_q[cidx]   <= bus_shared_in ? ST_S : ST_E;
          tag_q[cidx]  <= ctag;
          data_q[cidx] <= bus_fill_data;
        end
        default: begin
          st_q[cidx]   <= ST_M;
          tag_q[cidx]  <= ctag;
          data_q[cidx] <= bus_fill_data;
        end
      endcase
    end else if (cpu_done && cpu_we) begin
      data_q[cidx] <= cpu_wdata;
      st_q[cidx]   <= ST_M;
    end
  end
endmodule

module moesi_snoop_ctrl_chk #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_done,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic          snp_valid,
  input logic          snp_shared,
  input logic          snp_supply
);
  p_done_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req);

  p_snoop_stalls_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_done);

  p_supply_implies_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);

  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=>
      (!cpu_req || !$stable(cpu_addr) || !$stable(cpu_we) ||
       (bus_req && $stable(bus_cmd) && $stable(bus_addr))));

  p_wb_not_repeated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid && bus_cmd == 2'd3) |=>
      !(bus_req && bus_cmd == 2'd3 && bus_addr == $past(bus_addr)));

  p_fill_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid && bus_cmd != 2'd3) |=>
      (!cpu_req || snp_valid || !$stable(cpu_addr) || !$stable(cpu_we) || cpu_done));
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_shared(snp_shared),
  .snp_supply(snp_supply)
);

// File: tb/sim_moesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_snoop_ctrl;
  localparam int AW = 12, IDXW = 2, DW = 8, NL = 4;
  localparam int I = 0, S = 1, E = 2, O = 3, M = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done, bus_req, snp_shared, snp_supply;
  logic [DW-1:0] cpu_rdata, bus_wdata, snp_data;
  logic bus_gnt = 0, bus_shared_in = 0;
  logic [DW-1:0] bus_fill_data = '0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;

  int checks = 0, fails = 0;
  int sh_mode = 2;
  int m_st [NL];
  logic [AW-IDXW-1:0] m_tag [NL];
  logic [DW-1:0] m_data [NL];

  always #5 clk = ~clk;

  moesi_snoop_ctrl #(.AW(AW), .IDXW(IDXW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_shared_in(bus_shared_in), .bus_fill_data(bus_fill_data), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared),
    .snp_supply(snp_supply), .snp_data(snp_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_match(input logic [AW-1:0] a);
    return m_st[a[IDXW-1:0]] != I && m_tag[a[IDXW-1:0]] == a[AW-1:IDXW];
  endfunction

  function automatic bit m_hit(input bit we, input logic [AW-1:0] a);
    int s = m_st[a[IDXW-1:0]];
    return m_match(a) && (!we || s == M || s == E);
  endfunction

  function automatic int m_cmd(input bit we, input logic [AW-1:0] a);
    int s = m_st[a[IDXW-1:0]];
    if (!m_match(a) && (s == M || s == O)) return 3;
    if (!we) return 0;
    if (m_match(a)) return 2;
    return 1;
  endfunction

  function automatic string cmd_req(input int c);
    case (c)
      0: return "R3";
      1: return "R6";
      2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic snoop_now(input int c, input logic [AW-1:0] a, input bit pending);
    int ix = a[IDXW-1:0];
    bit hit = m_match(a);
    bit dirty = m_st[ix] == M || m_st[ix] == O;
    string rq = (!hit || c == 3) ? "R10" : (c == 0 ? "R8" : "R9");
    bit esh = hit && c != 3;
    bit esup = hit && dirty && (c == 0 || c == 1);
    snp_valid = 1; snp_cmd = c[1:0]; snp_addr = a;
    #1;
    chk(snp_shared === esh, rq, int'(snp_shared), int'(esh));
    chk(snp_supply === esup, rq, int'(snp_supply), int'(esup));
    if (esup) chk(snp_data === m_data[ix], rq, int'(snp_data), int'(m_data[ix]));
    if (pending) chk(cpu_done === 0, "R11", int'(cpu_done), 0);
    if (hit) begin
      if (c == 0 && m_st[ix] == M) m_st[ix] = O;
      else if (c == 0 && m_st[ix] == E) m_st[ix] = S;
      else if (c == 1 || c == 2) m_st[ix] = I;
    end
  endtask

  task automatic snoop_op(input int c, input logic [AW-1:0] a);
    @(negedge clk);
    snoop_now(c, a, 0);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input int inj);
    int ix = a[IDXW-1:0];
    bit injected = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int n = 0; n < 16; n++) begin
      int c;
      #1;
      if (m_hit(we, a)) begin
        chk(cpu_done === 1 && bus_req === 0, we ? "R4" : "R2", int'(cpu_done), 1);
        if (!we) chk(cpu_rdata === m_data[ix], "R2", int'(cpu_rdata), int'(m_data[ix]));
        else begin m_data[ix] = wd; m_st[ix] = M; end
        @(negedge clk);
        cpu_req = 0;
        return;
      end
      c = m_cmd(we, a);
      chk(cpu_done === 0 && bus_req === 1, "R12", int'(bus_req), 1);
      chk(bus_cmd === c[1:0], cmd_req(c), int'(bus_cmd), c);
      if (c == 3) begin
        chk(bus_addr === {m_tag[ix], a[IDXW-1:0]}, "R7", int'(bus_addr), int'({m_tag[ix], a[IDXW-1:0]}));
        chk(bus_wdata === m_data[ix], "R7", int'(bus_wdata), int'(m_data[ix]));
      end else chk(bus_addr === a, cmd_req(c), int'(bus_addr), int'(a));
      if ((inj >= 0 && !injected) || (inj == -1 && $urandom % 4 == 0)) begin
        int sc = (inj >= 0) ? inj : int'($urandom % 4);
        logic [AW-1:0] sa = (inj >= 0) ? a : {AW'($urandom % 3) << IDXW} | AW'(ix);
        injected = 1;
        snoop_now(sc, sa, 1);
        @(negedge clk);
        snp_valid = 0;
      end else begin
        bit sh = (sh_mode == 2) ? bit'($urandom % 2) : bit'(sh_mode);
        logic [DW-1:0] fd = DW'($urandom);
        bus_gnt = 1; bus_shared_in = sh; bus_fill_data = fd;
        case (c)
          3: m_st[ix] = I;
          2: m_st[ix] = M;
          0: begin m_st[ix] = sh ? S : E; m_tag[ix] = a[AW-1:IDXW]; m_data[ix] = fd; end
          default: begin m_st[ix] = M; m_tag[ix] = a[AW-1:IDXW]; m_data[ix] = fd; end
        endcase
        @(negedge clk);
        bus_gnt = 0;
      end
    end
    chk(0, "R12", 0, 1);
    cpu_req = 0;
  endtask

  function automatic logic [AW-1:0] ad(input int t, input int ix);
    return AW'((t << IDXW) | ix);
  endfunction

  initial begin
    #(200000 * 10);
    chk(0, "R12", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NL; i++) begin m_st[i] = I; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(bus_req === 0, "R1", int'(bus_req), 0);
    for (int i = 0; i < NL; i++) snoop_op(0, ad(0, i));

    sh_mode = 0;
    cpu_op(0, ad(0, 1), 8'h00, -2);          // R3 fill in E
    cpu_op(1, ad(0, 1), 8'hA5, -2);          // R4 silent E to M
    snoop_op(0, ad(0, 1));                   // R8 M supplies, to O
    snoop_op(0, ad(0, 1));                   // R8 O supplies again
    cpu_op(0, ad(0, 1), 8'h00, -2);          // R2 read hit in O
    cpu_op(1, ad(0, 1), 8'h3C, -2);          // R5 upgrade from O
    sh_mode = 1;
    cpu_op(0, ad(1, 1), 8'h00, -2);          // R7 writeback then R3 fill in S
    cpu_op(1, ad(1, 1), 8'h77, 1);           // R11 upgrade becomes read-exclusive
    snoop_op(1, ad(1, 1));                   // R9 supply then invalidate
    cpu_op(0, ad(2, 2), 8'h00, -2);          // S fill
    cpu_op(0, ad(0, 2), 8'h00, -2);          // R7 silent S eviction
    snoop_op(3, ad(0, 2));                   // R10 writeback ignored
    snoop_op(0, ad(3, 2));                   // R10 tag miss ignored
    cpu_op(0, ad(0, 2), 8'h00, -2);          // R10 line still readable
    snoop_op(2, ad(0, 2));                   // R9 upgrade invalidates without supply
    cpu_op(1, ad(0, 3), 8'h19, -2);          // R6 write miss

    sh_mode = 2;
    for (int k = 0; k < 600; k++) begin
      if ($urandom % 3 == 0) snoop_op(int'($urandom % 4), ad(int'($urandom % 3), int'($urandom % NL)));
      else cpu_op(bit'($urandom % 2), ad(int'($urandom % 3), int'($urandom % NL)), DW'($urandom), -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule